// File: doc/BRIEF.md
# DMA Destination Stream Ingress and Event Status

This block sits on the write side of a DMA engine. An incoming data stream cannot be stalled. The block holds its beats in a FIFO until the memory-write side drains them. A beat that cannot be stored is discarded and flagged, either because the FIFO is full or because a pause control is asserted. The block also watches several events:

- the FIFO fill level against a programmable watermark;
- write-address and write-response handshakes on the AXI side;
- two timeout-expiry pulses from counters kept elsewhere;
- completion of the transfer.

Every event lands in a 32-bit pre-mask status word. Software reads that word over a simple register port and clears it by writing ones. Interrupt masking is done downstream of this block. The block drives only raw status.

The watermark, the pause control and the remaining transfer size come in as input ports. An internal counter tracks the write responses still outstanding. A transfer counts as done only when three conditions hold together: the remaining size is zero, the FIFO is empty and no response is outstanding.

Top module: `dst_stream_status`

## Requirements
- R1: After reset the status word reads 0. Bits 31:8 and bit 0 always read 0. A register access with `reg_sel`=1 at address `STS_ADDR` (default 0x010) returns the status word combinationally. A bit set by an event is visible on the clock edge after the event cycle.
- R2: A write to `STS_ADDR` clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R3: If a bit is set by hardware and cleared by a software write in the same cycle, the bit ends up set.
- R4: A stream beat with `strm_valid`=1 is stored when `strm_pause`=0 and the fill level is below `DEPTH`. Stored beats leave in arrival order. `fifo_out_valid` is high whenever the FIFO is non-empty, and a beat is removed when `fifo_out_ready`=1.
- R5: A beat that arrives while the fill level equals `DEPTH` is discarded and sets bit 7. This holds even if a beat is removed in the same cycle.
- R6: A beat that arrives while `strm_pause`=1 is discarded and sets bit 7, even when the FIFO has room.
- R7: Any access (read or write) with `reg_sel`=1 at an address other than `STS_ADDR` sets bit 6. Such an access returns 0 on `reg_rdata` and clears nothing.
- R8: Bit 5 sets in the cycle in which the fill level goes from below `wm_level` to at least `wm_level`. It does not set again while the level stays at or above the watermark. A watermark of 0 disables this event.
- R9: A pulse on `tmo_mem` sets bit 4, and a pulse on `tmo_strm` sets bit 3.
- R10: A write-response handshake (`b_valid` and `b_ready`) with `b_resp` equal to 2 (SLVERR) or 3 (DECERR) sets bit 2. A response of 0 or 1 does not set it.
- R11: Bit 1 sets once when the condition "`xfer_left`=0, FIFO empty, no outstanding response" becomes true. The condition must be false in the previous cycle, and the condition holding after reset does not count.
- R12: The outstanding-response count rises on each write-address handshake and falls on each write-response handshake. It is unchanged when both happen in the same cycle. It never goes below 0 and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strm_valid | input | 1 | Stream beat present (no backpressure) |
| strm_data | input | DATA_W | Stream beat payload |
| strm_pause | input | 1 | Discard incoming beats while high |
| fifo_out_valid | output | 1 | FIFO holds at least one beat |
| fifo_out_data | output | DATA_W | Oldest beat in the FIFO |
| fifo_out_ready | input | 1 | Memory side takes the oldest beat |
| wm_level | input | $clog2(DEPTH+1) | Fill watermark, 0 disables |
| xfer_left | input | SIZE_W | Remaining transfer size |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| b_resp | input | 2 | Write-response code |
| tmo_mem | input | 1 | Memory-side timeout expiry pulse |
| tmo_strm | input | 1 | Stream-side timeout expiry pulse |
| reg_sel | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data (ones clear) |
| reg_rdata | output | 32 | Read data |

## Verification
The bench targets these corner cases:

- **A beat arriving at a full FIFO while a beat drains in the same cycle.** A design that admits it would corrupt the oldest entry or lose ordering.
- **A hardware set colliding with a write-one-to-clear.** A design where the clear wins would silently lose the event.
- **The watermark and completion edges.** A level-sensitive design would re-set bits that software just cleared, and would raise done straight out of reset.
- **A write response arriving with no address outstanding.** An unguarded counter would wrap and block done for good.
- **Accesses to a wrong address.** A design that decodes them loosely would clear real status bits.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int STS_W = 32;

    // bit positions inside the status word
    localparam int B_DONE    = 1;
    localparam int B_BRESP   = 2;
    localparam int B_TO_STRM = 3;
    localparam int B_TO_MEM  = 4;
    localparam int B_WMARK   = 5;
    localparam int B_DECODE  = 6;
    localparam int B_OVFL    = 7;

    localparam logic [STS_W-1:0] STS_IMPL_MASK = 32'h0000_00FE;

    // event vector, ordered to match bits 7..1 of the status word
    typedef struct packed {
        logic ovfl;
        logic decode;
        logic wmark;
        logic to_mem;
        logic to_strm;
        logic bresp;
        logic done;
    } evt_t;

    function automatic logic [STS_W-1:0] evt_to_word(evt_t e);
        return {{(STS_W-8){1'b0}}, e, 1'b0};
    endfunction

    function automatic logic resp_is_error(logic [1:0] r);
        return (r == 2'b10) || (r == 2'b11);
    endfunction

endpackage

// File: rtl/dst_fifo.sv
module dst_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         pop,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // R5
    fifo_no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    // R4
    fifo_no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);
    // R4
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/dst_ingress.sv
module dst_ingress (
    input  logic clk,
    input  logic rst,
    input  logic strm_valid,
    input  logic strm_pause,
    input  logic fifo_full,
    output logic push,
    output logic drop
);
    // no backpressure: a beat is either stored or discarded in its cycle
    assign push = strm_valid && !strm_pause && !fifo_full;
    assign drop = strm_valid && (strm_pause || fifo_full);

    // R6
    pause_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (strm_valid && strm_pause) |-> (drop && !push));
    // R5
    push_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push, drop}));

endmodule

// File: rtl/dst_events.sv
module dst_events
    import dst_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SIZE_W = 16,
    parameter int OUT_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(DEPTH+1)-1:0]  fill,
    input  logic                        fifo_empty,
    input  logic [$clog2(DEPTH+1)-1:0]  wm_level,
    input  logic [SIZE_W-1:0]           xfer_left,
    input  logic                        aw_hs,
    input  logic                        b_hs,
    input  logic [1:0]                  b_resp,
    input  logic                        tmo_mem,
    input  logic                        tmo_strm,
    input  logic                        drop,
    input  logic                        decode_err,
    output evt_t                        evt
);
    localparam logic [OUT_W-1:0] OUT_MAX = '1;

    logic [OUT_W-1:0] outst;
    logic             at_wm, wm_prev;
    logic             done_cond, done_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst <= '0;
        end else if (aw_hs && !b_hs) begin
            if (outst != OUT_MAX) outst <= outst + 1'b1;
        end else if (b_hs && !aw_hs) begin
            if (outst != '0) outst <= outst - 1'b1;
        end
    end

    assign at_wm     = (wm_level != '0) && (fill >= wm_level);
    assign done_cond = (xfer_left == '0) && fifo_empty && (outst == '0);

    // done_prev resets high so a condition already true at reset is not an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            wm_prev   <= 1'b0;
            done_prev <= 1'b1;
        end else begin
            wm_prev   <= at_wm;
            done_prev <= done_cond;
        end
    end

    always_comb begin
        evt         = '0;
        evt.ovfl    = drop;
        evt.decode  = decode_err;
        evt.wmark   = at_wm && !wm_prev;
        evt.to_mem  = tmo_mem;
        evt.to_strm = tmo_strm;
        evt.bresp   = b_hs && resp_is_error(b_resp);
        evt.done    = done_cond && !done_prev;
    end

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !evt.done);
    // R12
    outst_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (outst == '0 && b_hs && !aw_hs) |=> (outst == '0));
    // R12
    outst_step_chk: assert property (@(posedge clk) disable iff (rst)
        (aw_hs && !b_hs && outst != OUT_MAX) |=> (outst == $past(outst) + 1'b1));
    // R8
    wm_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt.wmark |=> !evt.wmark);

endmodule

// File: rtl/dst_status_reg.sv
module dst_status_reg
    import dst_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] STS_ADDR = 12'h010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STS_W-1:0]  reg_wdata,
    output logic [STS_W-1:0]  reg_rdata,
    output logic              decode_err,
    input  evt_t              evt
);
    logic [STS_W-1:0] status, set_w, clr_w;
    logic             hit;

    assign hit        = (reg_addr == STS_ADDR);
    assign decode_err = reg_sel && !hit;
    assign set_w      = evt_to_word(evt);
    assign clr_w      = (reg_sel && reg_write && hit) ? reg_wdata : '0;

    // set is OR-ed after the clear so a same-cycle event survives
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= ((status & ~clr_w) | set_w) & STS_IMPL_MASK;
    end

    assign reg_rdata = (reg_sel && hit) ? status : '0;

    // R1
    sts_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (status & ~STS_IMPL_MASK) == '0);
    // R3
    sts_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_w != '0) |=> ((status & $past(set_w)) == $past(set_w)));
    // R2
    sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_sel && set_w == '0) |=> (status == $past(status)));
    // R7
    sts_miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && !hit) |-> (reg_rdata == '0));

endmodule

// File: rtl/dst_stream_status.sv
module dst_stream_status
    import dst_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                DEPTH    = 8,
    parameter int                SIZE_W   = 16,
    parameter int                OUT_W    = 8,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] STS_ADDR = 12'h010
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        strm_valid,
    input  logic [DATA_W-1:0]           strm_data,
    input  logic                        strm_pause,
    output logic                        fifo_out_valid,
    output logic [DATA_W-1:0]           fifo_out_data,
    input  logic                        fifo_out_ready,
    input  logic [$clog2(DEPTH+1)-1:0]  wm_level,
    input  logic [SIZE_W-1:0]           xfer_left,
    input  logic                        aw_valid,
    input  logic                        aw_ready,
    input  logic                        b_valid,
    input  logic                        b_ready,
    input  logic [1:0]                  b_resp,
    input  logic                        tmo_mem,
    input  logic                        tmo_strm,
    input  logic                        reg_sel,
    input  logic                        reg_write,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, drop, pop, full, empty, decode_err;
    logic [CNT_W-1:0] fill;
    evt_t             evt;

    assign pop            = fifo_out_ready && !empty;
    assign fifo_out_valid = !empty;

    dst_ingress u_ingress (
        .clk        (clk),
        .rst        (rst),
        .strm_valid (strm_valid),
        .strm_pause (strm_pause),
        .fifo_full  (full),
        .push       (push),
        .drop       (drop)
    );

    dst_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (strm_data),
        .pop   (pop),
        .rdata (fifo_out_data),
        .count (fill),
        .full  (full),
        .empty (empty)
    );

    dst_events #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .OUT_W(OUT_W)) u_events (
        .clk        (clk),
        .rst        (rst),
        .fill       (fill),
        .fifo_empty (empty),
        .wm_level   (wm_level),
        .xfer_left  (xfer_left),
        .aw_hs      (aw_valid && aw_ready),
        .b_hs       (b_valid && b_ready),
        .b_resp     (b_resp),
        .tmo_mem    (tmo_mem),
        .tmo_strm   (tmo_strm),
        .drop       (drop),
        .decode_err (decode_err),
        .evt        (evt)
    );

    dst_status_reg #(.ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR)) u_status (
        .clk        (clk),
        .rst        (rst),
        .reg_sel    (reg_sel),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .decode_err (decode_err),
        .evt        (evt)
    );

    // R4
    out_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_out_valid && !fifo_out_ready && !strm_valid) |=> fifo_out_valid);

endmodule

// File: tb/sim_dst_stream_status.sv
module sim_dst_stream_status;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int OUT_MAX = 255;
    localparam logic [11:0] STS_ADDR = 12'h010;

    typedef struct {
        logic              sv;
        logic [DATA_W-1:0] sd;
        logic              ps;
        logic              ordy;
        logic              awv, awr, bv, br;
        logic [1:0]        bresp;
        logic              tm, ts;
        logic              sel, wr;
        logic [11:0]       addr;
        logic [31:0]       wd;
        logic [CNT_W-1:0]  thr;
        logic [SIZE_W-1:0] rem;
    } stim_t;

    logic clk = 1'b0, rst = 1'b1;
    logic strm_valid, strm_pause, fifo_out_ready, aw_valid, aw_ready;
    logic b_valid, b_ready, tmo_mem, tmo_strm, reg_sel, reg_write;
    logic [DATA_W-1:0] strm_data, fifo_out_data;
    logic fifo_out_valid;
    logic [CNT_W-1:0] wm_level;
    logic [SIZE_W-1:0] xfer_left;
    logic [1:0] b_resp;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    always #4 clk = ~clk;   // 125 MHz

    dst_stream_status #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SIZE_W(SIZE_W),
                        .STS_ADDR(STS_ADDR)) u0 (
        .clk(clk), .rst(rst), .strm_valid(strm_valid), .strm_data(strm_data),
        .strm_pause(strm_pause), .fifo_out_valid(fifo_out_valid),
        .fifo_out_data(fifo_out_data), .fifo_out_ready(fifo_out_ready),
        .wm_level(wm_level), .xfer_left(xfer_left), .aw_valid(aw_valid),
        .aw_ready(aw_ready), .b_valid(b_valid), .b_ready(b_ready),
        .b_resp(b_resp), .tmo_mem(tmo_mem), .tmo_strm(tmo_strm),
        .reg_sel(reg_sel), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    // reference model state
    logic [DATA_W-1:0] mq[$];
    logic [7:0] m_sts;
    logic m_wm_prev, m_done_prev;
    int m_outst;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    function automatic stim_t idle();
        stim_t s;
        s.sv = 0; s.sd = '0; s.ps = 0; s.ordy = 0; s.awv = 0; s.awr = 0;
        s.bv = 0; s.br = 0; s.bresp = 0; s.tm = 0; s.ts = 0; s.sel = 0;
        s.wr = 0; s.addr = STS_ADDR; s.wd = '0; s.thr = '0; s.rem = '0;
        return s;
    endfunction

    function automatic string req_of(int b);
        case (b)
            7: return "R5/R6";
            6: return "R7";
            5: return "R8";
            4: return "R9";
            3: return "R9";
            2: return "R10";
            1: return "R11";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [7:0] model_set(stim_t s);
        logic [7:0] st = '0;
        bit full = (mq.size() == DEPTH);
        bit wm = (s.thr != 0) && (mq.size() >= s.thr);
        bit dc = (s.rem == 0) && (mq.size() == 0) && (m_outst == 0);
        if (s.sv && (s.ps || full))            st[7] = 1;
        if (s.sel && s.addr != STS_ADDR)       st[6] = 1;
        if (wm && !m_wm_prev)                  st[5] = 1;
        if (s.tm)                              st[4] = 1;
        if (s.ts)                              st[3] = 1;
        if (s.bv && s.br && s.bresp[1])        st[2] = 1;
        if (dc && !m_done_prev)                st[1] = 1;
        return st;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle(stim_t s);
        logic [7:0] st, clr;
        bit aw, b, pop, push;
        @(negedge clk);
        strm_valid = s.sv; strm_data = s.sd; strm_pause = s.ps;
        fifo_out_ready = s.ordy; aw_valid = s.awv; aw_ready = s.awr;
        b_valid = s.bv; b_ready = s.br; b_resp = s.bresp; tmo_mem = s.tm;
        tmo_strm = s.ts; reg_sel = s.sel; reg_write = s.wr; reg_addr = s.addr;
        reg_wdata = s.wd; wm_level = s.thr; xfer_left = s.rem;
        #3;
        if (!rst) begin
            // R4
            check(fifo_out_valid == (mq.size() != 0), "R4 valid",
                  32'(fifo_out_valid), 32'(mq.size() != 0));
            if (mq.size() != 0)
                check(fifo_out_data == mq[0], "R4 data", fifo_out_data, mq[0]);
            if (s.sel && s.addr == STS_ADDR) begin
                for (int b2 = 0; b2 < 32; b2++) begin
                    logic expb = (b2 < 8) ? m_sts[b2] : 1'b0;
                    if (reg_rdata[b2] !== expb)
                        check(0, req_of(b2), reg_rdata, {24'b0, m_sts});
                end
                check(reg_rdata == {24'b0, m_sts}, "R1 status", reg_rdata, {24'b0, m_sts});
            end else if (s.sel) begin
                // R7
                check(reg_rdata == 0, "R7 miss read", reg_rdata, 0);
            end
        end
        @(posedge clk);
        if (rst) begin
            mq.delete(); m_sts = 0; m_wm_prev = 0; m_done_prev = 1; m_outst = 0;
        end else begin
            st   = model_set(s);
            clr  = (s.sel && s.wr && s.addr == STS_ADDR) ? s.wd[7:0] : 8'h00;
            m_sts = ((m_sts & ~clr) | st) & 8'hFE;
            m_wm_prev   = (s.thr != 0) && (mq.size() >= s.thr);
            m_done_prev = (s.rem == 0) && (mq.size() == 0) && (m_outst == 0);
            aw = s.awv && s.awr;
            b  = s.bv && s.br;
            if (aw && !b && m_outst != OUT_MAX) m_outst++;
            else if (b && !aw && m_outst != 0) m_outst--;
            pop  = s.ordy && (mq.size() != 0);
            push = s.sv && !s.ps && (mq.size() != DEPTH);
            if (pop) void'(mq.pop_front());
            if (push) mq.push_back(s.sd);
        end
    endtask

    task automatic rd();
        stim_t s = idle();
        s.sel = 1;
        cycle(s);
    endtask

    task automatic wr(logic [31:0] d);
        stim_t s = idle();
        s.sel = 1; s.wr = 1; s.wd = d;
        cycle(s);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        void'($urandom(32'h5EED_0042));
        m_sts = 0; m_wm_prev = 0; m_done_prev = 1; m_outst = 0;
        for (int i = 0; i < 4; i++) cycle(idle());
        rst = 0;

        // R1 reset value; R11 no done straight out of reset
        rd(); rd();

        // R7 miss access sets bit 6, R2 zero write keeps, one write clears
        s = idle(); s.sel = 1; s.addr = 12'h020; cycle(s);
        s.wr = 1; s.wd = 32'hFFFF_FFFF; cycle(s);
        rd(); wr(32'h0000_0000); rd(); wr(32'h0000_0040); rd();

        // R8 watermark 4, R5 overflow at full with simultaneous drain
        for (int i = 0; i < DEPTH + 2; i++) begin
            s = idle(); s.thr = 4; s.sv = 1; s.sd = 32'hA000_0000 + i; s.sel = 1;
            if (i == DEPTH + 1) s.ordy = 1;
            cycle(s);
        end
        rd(); wr(32'hFF);
        for (int i = 0; i < DEPTH; i++) begin
            s = idle(); s.thr = 4; s.ordy = 1; s.sel = 1; cycle(s);
        end
        // R6 pause drops with room
        s = idle(); s.sv = 1; s.ps = 1; s.sd = 32'hDEAD_BEEF; cycle(s);
        rd(); wr(32'hFF);

        // R3 set and clear of bit 4 in one cycle; R9 R10
        s = idle(); s.tm = 1; s.sel = 1; s.wr = 1; s.wd = 32'h10; cycle(s);
        rd();
        s = idle(); s.ts = 1; s.bv = 1; s.br = 1; s.bresp = 2'b01; cycle(s);
        rd();
        s = idle(); s.bv = 1; s.br = 1; s.bresp = 2'b11; cycle(s);
        rd(); wr(32'hFF);

        // R12 outstanding count gates R11 done
        s = idle(); s.rem = 3; s.awv = 1; s.awr = 1; cycle(s); cycle(s);
        s = idle(); rd();
        s = idle(); s.bv = 1; s.br = 1; cycle(s);
        rd();
        cycle(s); rd(); rd();
        s = idle(); s.bv = 1; s.br = 1; cycle(s);   // R12 response with none outstanding
        rd(); wr(32'hFF);

        // random phase
        begin
            logic [CNT_W-1:0] thr = 3;
            for (int i = 0; i < 4000; i++) begin
                if (i % 250 == 0) thr = CNT_W'($urandom_range(0, DEPTH));
                s = idle();
                s.thr  = thr;
                s.sv   = ($urandom_range(0, 9) < 6);
                s.sd   = $urandom;
                s.ps   = ($urandom_range(0, 9) == 0);
                s.ordy = ($urandom_range(0, 9) < 4);
                s.awv  = $urandom_range(0, 1); s.awr = $urandom_range(0, 1);
                s.bv   = $urandom_range(0, 1); s.br  = $urandom_range(0, 1);
                s.bresp = 2'($urandom_range(0, 3));
                s.tm   = ($urandom_range(0, 19) == 0);
                s.ts   = ($urandom_range(0, 19) == 0);
                s.sel  = ($urandom_range(0, 9) < 3);
                s.addr = ($urandom_range(0, 9) < 8) ? STS_ADDR : 12'($urandom);
                s.wr   = $urandom_range(0, 1);
                s.wd   = $urandom;
                s.rem  = ($urandom_range(0, 1) == 0) ? '0 : SIZE_W'($urandom_range(1, 9));
                cycle(s);
            end
        end
        rd();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule